// File: doc/BRIEF.md
# Instruction Flush Synchronization Sequencer

This block runs the pipeline operation that brings instruction fetch back in line with data memory after a program has stored into locations that hold code. Decode presents a flush request together with the program counter of the flush. The block accepts the request and then waits until the store buffer reports that no older cacheable store is still outstanding. For ordering purposes the flush behaves like a store: it cannot overtake older stores, and later memory operations are held back because decode is stalled.

Once the stores have drained, the block sends a single-cycle invalidate to every instruction fetch buffer and prefetch buffer. In the next cycle it redirects fetch to the instruction that directly follows the flush. A pipeline kill that arrives while the block is still waiting for stores abandons the sequence cleanly. A new request that arrives while a sequence is running is held off, not lost: decode keeps it asserted and the block takes it once it is free again.

Top module: `ifetch_flush_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `busy_o`, `redir_vld_o` and every bit of `fbuf_inv_o` are low.
- R2: When `flush_req_i` is high and `busy_o` is low at a clock edge, the request is taken and its `flush_pc_i` captured. `busy_o` is high from the next cycle through the redirect cycle inclusive.
- R3: After it takes a request, the block stays busy without invalidating for as long as `st_pend_i` is nonzero. This wait always lasts at least one cycle. The invalidate starts in the cycle after the first edge at which the block is waiting and sees `st_pend_i == 0`.
- R4: The invalidate drives all `NUM_BUF` bits of `fbuf_inv_o` high together, for exactly one cycle, and never at any other time.
- R5: In the cycle directly after the invalidate, `redir_vld_o` is high for one cycle and `redir_pc_o` equals the captured PC plus 4, modulo 2^`PC_W` (0xFFFFFFFC gives 0). `redir_vld_o` is low at every other time.
- R6: `busy_o` drops in the cycle after the redirect cycle. With the store count already zero, a full sequence spans three busy cycles: wait, invalidate, redirect.
- R7: A request that is present while `busy_o` is high is not taken, and changes on `flush_pc_i` during that time have no effect on the redirect target. A request held high is taken at the first edge where `busy_o` is low, with the PC it carries then.
- R8: If `kill_i` is high at an edge while the block is waiting for stores, the sequence is abandoned. This holds even when the count is zero at that edge. `busy_o` is low in the next cycle, and no invalidate or redirect follows.
- R9: `kill_i` has no effect when the block is idle, invalidating or redirecting. A sequence that is already past the wait finishes its invalidate and redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_req_i | input | 1 | Flush request from decode, held until taken |
| flush_pc_i | input | PC_W | Program counter of the flush instruction |
| st_pend_i | input | CNT_W | Count of outstanding older cacheable stores |
| kill_i | input | 1 | Pipeline kill, aborts a sequence still waiting for stores |
| busy_o | output | 1 | Sequence in progress; stalls decode |
| fbuf_inv_o | output | NUM_BUF | Invalidate strobe, one bit per fetch or prefetch buffer |
| redir_vld_o | output | 1 | Fetch redirect strobe |
| redir_pc_o | output | PC_W | Fetch restart address |

## Verification
A wrong state register in this block shows up at the ports within a cycle or two. An early exit from the store wait raises `fbuf_inv_o` while `st_pend_i` is still nonzero. A skipped or repeated state either loses the one-cycle gap between invalidate and redirect or leaves `busy_o` high for too long. A capture enable that is wrong only shows at the redirect: `redir_pc_o` carries the PC of a request that should have been held off, or it is missing the +4. A kill path that is wrong shows in the cycle after the kill, when `busy_o` stays high or an invalidate appears.

// File: rtl/ifetch_flush_pkg.sv
package ifetch_flush_pkg;

    localparam int unsigned INSTR_BYTES = 4;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_DRAIN = 2'd1,
        FS_INVAL = 2'd2,
        FS_REDIR = 2'd3
    } fs_state_e;

    function automatic logic fs_is_busy(input fs_state_e s);
        return s != FS_IDLE;
    endfunction

endpackage

// File: rtl/ifetch_flush_fsm.sv
module ifetch_flush_fsm
    import ifetch_flush_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_i,
    input  logic      drained_i,
    input  logic      kill_i,
    output fs_state_e state_o,
    output logic      accept_o
);
    fs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (req_i) state_d = FS_DRAIN;
            FS_DRAIN: begin
                // a kill wins over a drained count in the same cycle
                if (kill_i)         state_d = FS_IDLE;
                else if (drained_i) state_d = FS_INVAL;
            end
            FS_INVAL: state_d = FS_REDIR;
            FS_REDIR: state_d = FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FS_IDLE;
        else     state_q <= state_d;
    end

    assign accept_o = (state_q == FS_IDLE) && req_i;
    assign state_o  = state_q;
endmodule

// File: rtl/ifetch_flush_drain.sv
module ifetch_flush_drain #(
    parameter int unsigned CNT_W = 6
) (
    input  logic [CNT_W-1:0] pend_i,
    output logic             drained_o
);
    assign drained_o = (pend_i == '0);
endmodule

// File: rtl/ifetch_flush_tgt.sv
module ifetch_flush_tgt
    import ifetch_flush_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] target_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst)         pc_q <= '0;
        else if (load_i) pc_q <= pc_i;
    end

    assign target_o = pc_q + STEP;
endmodule

// File: rtl/ifetch_flush_inv.sv
module ifetch_flush_inv #(
    parameter int unsigned NUM_BUF = 4
) (
    input  logic               fire_i,
    output logic [NUM_BUF-1:0] inv_o
);
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        assign inv_o[b] = fire_i;
    end
endmodule

// File: rtl/ifetch_flush_seq.sv
module ifetch_flush_seq
    import ifetch_flush_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned NUM_BUF = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush_req_i,
    input  logic [PC_W-1:0]    flush_pc_i,
    input  logic [CNT_W-1:0]   st_pend_i,
    input  logic               kill_i,
    output logic               busy_o,
    output logic [NUM_BUF-1:0] fbuf_inv_o,
    output logic               redir_vld_o,
    output logic [PC_W-1:0]    redir_pc_o
);
    fs_state_e state;
    logic      accept;
    logic      drained;

    ifetch_flush_drain #(.CNT_W(CNT_W)) u_drain (
        .pend_i    (st_pend_i),
        .drained_o (drained)
    );

    ifetch_flush_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_i     (flush_req_i),
        .drained_i (drained),
        .kill_i    (kill_i),
        .state_o   (state),
        .accept_o  (accept)
    );

    ifetch_flush_tgt #(.PC_W(PC_W)) u_tgt (
        .clk      (clk),
        .rst      (rst),
        .load_i   (accept),
        .pc_i     (flush_pc_i),
        .target_o (redir_pc_o)
    );

    ifetch_flush_inv #(.NUM_BUF(NUM_BUF)) u_inv (
        .fire_i (state == FS_INVAL),
        .inv_o  (fbuf_inv_o)
    );

    assign busy_o      = fs_is_busy(state);
    assign redir_vld_o = (state == FS_REDIR);
endmodule

// File: rtl/ifetch_flush_seq_chk.sv
module ifetch_flush_seq_chk #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned NUM_BUF = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               flush_req_i,
    input logic [PC_W-1:0]    flush_pc_i,
    input logic [CNT_W-1:0]   st_pend_i,
    input logic               kill_i,
    input logic               busy_o,
    input logic [NUM_BUF-1:0] fbuf_inv_o,
    input logic               redir_vld_o,
    input logic [PC_W-1:0]    redir_pc_o
);
    logic [PC_W-1:0] shadow_pc;
    logic            inv_any;
    logic            waiting;

    always_ff @(posedge clk) begin
        if (rst) shadow_pc <= '0;
        else if (flush_req_i && !busy_o) shadow_pc <= flush_pc_i;
    end

    assign inv_any = |fbuf_inv_o;
    assign waiting = busy_o && !inv_any && !redir_vld_o;

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !inv_any && !redir_vld_o));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_req_i && !busy_o) |=> busy_o);

    // R3
    inv_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
        inv_any |-> ($past(st_pend_i) == '0 && $past(busy_o) && !$past(inv_any)));

    // R4
    inv_all_chk: assert property (@(posedge clk) disable iff (rst)
        inv_any |-> (&fbuf_inv_o));

    // R4
    inv_single_chk: assert property (@(posedge clk) disable iff (rst)
        inv_any |=> (!inv_any && redir_vld_o));

    // R5
    redir_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        redir_vld_o |-> (redir_pc_o == shadow_pc + PC_W'(4) && $past(inv_any)));

    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        redir_vld_o |=> !busy_o);

    // R8
    kill_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (waiting && kill_i) |=> (!busy_o && !inv_any));

    // R9
    late_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_any && kill_i) |=> redir_vld_o);
endmodule

bind ifetch_flush_seq ifetch_flush_seq_chk #(
    .PC_W(PC_W), .CNT_W(CNT_W), .NUM_BUF(NUM_BUF)
) u_chk (.*);

// File: tb/ifetch_flush_seq_tb_top.sv
module ifetch_flush_seq_tb_top;
    localparam int unsigned PC_W    = 32;
    localparam int unsigned CNT_W   = 6;
    localparam int unsigned NUM_BUF = 4;
    localparam logic [NUM_BUF-1:0] ALL_INV = '1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               flush_req_i = 1'b0;
    logic [PC_W-1:0]    flush_pc_i = '0;
    logic [CNT_W-1:0]   st_pend_i = '0;
    logic               kill_i = 1'b0;
    logic               busy_o;
    logic [NUM_BUF-1:0] fbuf_inv_o;
    logic               redir_vld_o;
    logic [PC_W-1:0]    redir_pc_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ifetch_flush_seq #(.PC_W(PC_W), .CNT_W(CNT_W), .NUM_BUF(NUM_BUF)) dut_i (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_outs(input string tag, input logic b, input logic [NUM_BUF-1:0] inv,
                            input logic rv);
        chk({tag, " busy"}, 64'(busy_o), 64'(b));
        chk({tag, " inv"}, 64'(fbuf_inv_o), 64'(inv));
        chk({tag, " redir"}, 64'(redir_vld_o), 64'(rv));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        flush_req_i = 1'b1;
        tick(); tick();
        chk_outs("R1 in reset", 1'b0, '0, 1'b0);
        flush_req_i = 1'b0;
        rst = 1'b0;
        tick();
        chk_outs("R1 after reset", 1'b0, '0, 1'b0);
    endtask

    task automatic t_basic();
        st_pend_i = '0;
        flush_req_i = 1'b1;
        flush_pc_i = 32'h0000_1000;
        tick();
        flush_req_i = 1'b0;
        chk_outs("R2 wait cycle", 1'b1, '0, 1'b0);
        tick();
        chk_outs("R4 invalidate", 1'b1, ALL_INV, 1'b0);
        tick();
        chk_outs("R5 redirect", 1'b1, '0, 1'b1);
        chk("R5 target", 64'(redir_pc_o), 64'h1004);
        tick();
        chk_outs("R6 idle", 1'b0, '0, 1'b0);
    endtask

    task automatic t_drain();
        st_pend_i = 6'd3;
        flush_req_i = 1'b1;
        flush_pc_i = 32'h0000_2040;
        tick();
        flush_req_i = 1'b0;
        for (int i = 2; i >= 1; i--) begin
            chk_outs("R3 held while stores pend", 1'b1, '0, 1'b0);
            st_pend_i = CNT_W'(i);
            tick();
        end
        chk_outs("R3 held last", 1'b1, '0, 1'b0);
        st_pend_i = '0;
        tick();
        chk_outs("R3 inv after drain", 1'b1, ALL_INV, 1'b0);
        tick();
        chk("R5 target after drain", 64'(redir_pc_o), 64'h2044);
        chk("R5 redirect after drain", 64'(redir_vld_o), 64'd1);
        tick();
        chk("R6 busy drop", 64'(busy_o), 64'd0);
    endtask

    task automatic t_held();
        st_pend_i = 6'd1;
        flush_req_i = 1'b1;
        flush_pc_i = 32'h0000_3000;
        tick();
        flush_pc_i = 32'h0000_5000;
        tick();
        chk("R7 still busy", 64'(busy_o), 64'd1);
        st_pend_i = '0;
        flush_pc_i = 32'h0000_6000;
        tick();
        tick();
        chk("R7 first target", 64'(redir_pc_o), 64'h3004);
        tick();
        chk("R7 idle one cycle", 64'(busy_o), 64'd0);
        tick();
        flush_req_i = 1'b0;
        chk("R7 held taken", 64'(busy_o), 64'd1);
        tick();
        chk("R7 held inv", 64'(fbuf_inv_o), 64'(ALL_INV));
        tick();
        chk("R7 held target", 64'(redir_pc_o), 64'h6004);
        tick();
        chk("R7 held done", 64'(busy_o), 64'd0);
    endtask

    task automatic t_kill();
        st_pend_i = 6'd2;
        flush_req_i = 1'b1;
        flush_pc_i = 32'h0000_7000;
        tick();
        flush_req_i = 1'b0;
        kill_i = 1'b1;
        tick();
        kill_i = 1'b0;
        chk_outs("R8 abort", 1'b0, '0, 1'b0);
        st_pend_i = '0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_outs("R8 quiet", 1'b0, '0, 1'b0);
        end
        flush_req_i = 1'b1;
        flush_pc_i = 32'h0000_7100;
        tick();
        flush_req_i = 1'b0;
        kill_i = 1'b1;
        tick();
        kill_i = 1'b0;
        chk_outs("R8 abort with zero count", 1'b0, '0, 1'b0);
        tick();
        chk_outs("R8 quiet after zero", 1'b0, '0, 1'b0);
    endtask

    task automatic t_late_kill();
        st_pend_i = '0;
        kill_i = 1'b1;
        tick();
        chk_outs("R9 kill idle", 1'b0, '0, 1'b0);
        kill_i = 1'b0;
        flush_req_i = 1'b1;
        flush_pc_i = 32'h0000_8000;
        tick();
        flush_req_i = 1'b0;
        tick();
        kill_i = 1'b1;
        chk_outs("R9 inv before kill", 1'b1, ALL_INV, 1'b0);
        tick();
        chk_outs("R9 redirect despite kill", 1'b1, '0, 1'b1);
        chk("R9 target", 64'(redir_pc_o), 64'h8004);
        tick();
        kill_i = 1'b0;
        chk("R9 done", 64'(busy_o), 64'd0);
    endtask

    task automatic t_wrap();
        st_pend_i = '0;
        flush_req_i = 1'b1;
        flush_pc_i = 32'hFFFF_FFFC;
        tick();
        flush_req_i = 1'b0;
        tick();
        tick();
        chk("R5 wrap redirect", 64'(redir_vld_o), 64'd1);
        chk("R5 wrap target", 64'(redir_pc_o), 64'h0);
        tick();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_drain();
        t_held();
        t_kill();
        t_late_kill();
        t_wrap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule